// File: doc/BRIEF.md
# Fractional-Dithering PWM Generator

This block is a single-channel PWM timer whose period and pulse width each carry a fractional part. Each PWM cycle is a whole number of clocks. Over a run of cycles, selected cycles are lengthened by one clock so that the average period and the average high time reach a resolution of 1/16, 1/32 or 1/64 of a clock. Period dithering and pulse-width dithering run independently of each other.

Software-free operation: the surrounding logic presents a period word, a compare word, a dither resolution and a counting direction. The block samples them once per PWM cycle, at the cycle boundary. It drives the PWM waveform and a one-clock strobe that marks the first clock of every cycle.

Top module: `frac_pwm`

## Requirements
- R1: `res_sel` picks the dither accumulator width. Code 0 turns dithering off. Code 1 selects 4 bits (mask 0x0F, steps of 1/16). Code 2 selects 5 bits (mask 0x1F, steps of 1/32). Code 3 selects 6 bits (mask 0x3F, steps of 1/64). An accumulator always holds a value within its mask.
- R2: In both `period_word` and `cmp_word`, bits [5:0] are the dither increment and bits [WORD_W-1:6] are the integer count in clocks.
- R3: With `dir_down`=0, each new cycle adds the increment to its accumulator. The cycle is one clock longer exactly when the accumulator plus the increment exceeds the mask. The accumulator keeps the sum modulo mask+1.
- R4: With `dir_down`=1, the accumulator advances in the same way. The extra clock is added on every cycle except those where that sum exceeds the mask.
- R5: A zero period increment leaves every period at its integer value. A zero compare increment leaves every high time at its integer value. Either holds in both directions, and `res_sel`=0 disables both kinds of dithering.
- R6: Over 2^n consecutive cycles that start from a cleared accumulator, the total period is 2^n times the integer period plus the increment when up-counting. When down-counting it is 2^n times the integer period plus (2^n minus the increment).
- R7: Compare dithering lengthens only the high time. The cycle lengths stay those set by the period word, and over 2^n cycles the total high time is 2^n times the integer compare plus the increment.
- R8: The period and compare accumulators are separate. Both are cleared by reset, and both are cleared when a cycle starts with a resolution different from that of the previous cycle.
- R9: Words, resolution and direction are sampled only at a cycle start, so changing them during a cycle does not change that cycle.
- R10: `cyc_start` is high during the first clock of every cycle. `pwm_out` is high for the first W clocks of a cycle, where W is the effective compare count. If W is at or above the effective period, `pwm_out` stays high for the whole cycle. A W of zero keeps it low.
- R11: During reset, and while `en` is low, both outputs are low. The first cycle begins at the first clock edge with `en` high. An effective period of zero is run as one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low stops the timer |
| res_sel | input | 2 | Dither resolution code (R1) |
| dir_down | input | 1 | 1 selects down-counting extra-clock placement |
| period_word | input | WORD_W | Integer period in the upper bits, period increment in bits [5:0] |
| cmp_word | input | WORD_W | Integer compare in the upper bits, compare increment in bits [5:0] |
| pwm_out | output | 1 | PWM waveform |
| cyc_start | output | 1 | High in the first clock of each PWM cycle |

## Verification
Every measured cycle length and high time is compared with a model of the accumulators. The model runs with the 4-, 5- and 6-bit resolutions, in both directions, and with increments that are zero on one side and non-zero on the other. The zero-versus-non-zero pairing is what separates period stretching from pulse stretching. Sums over a full 2^n-cycle window confirm the fractional averages, and they expose a direction inversion or a wrong mask that a single cycle would not show. Further runs switch the resolution after the accumulators have moved, alter the words in mid-cycle, and drive compare values at, above and at zero relative to the period, as well as an integer period of zero.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;

    localparam int FRAC_W = 6;

    typedef enum logic [1:0] {
        DITH_OFF = 2'd0,
        DITH_16  = 2'd1,
        DITH_32  = 2'd2,
        DITH_64  = 2'd3
    } dith_res_e;

    typedef struct packed {
        logic              extra;
        logic [FRAC_W-1:0] acc_nxt;
    } dith_step_t;

    function automatic logic [FRAC_W-1:0] res_mask(dith_res_e r);
        case (r)
            DITH_16: return 6'h0F;
            DITH_32: return 6'h1F;
            DITH_64: return 6'h3F;
            default: return 6'h00;
        endcase
    endfunction

    // One accumulator step: overflow decides the extra clock, direction inverts it
    function automatic dith_step_t dith_step(logic [FRAC_W-1:0] acc,
                                             logic [FRAC_W-1:0] inc,
                                             dith_res_e r, logic down);
        dith_step_t        s;
        logic [FRAC_W:0]   sum;
        logic [FRAC_W-1:0] m;
        logic              ovf;
        logic              active;
        m      = res_mask(r);
        sum    = {1'b0, acc} + {1'b0, inc};
        ovf    = sum > {1'b0, m};
        active = (r != DITH_OFF) && (inc != '0);
        s.extra   = active && (down ? !ovf : ovf);
        s.acc_nxt = sum[FRAC_W-1:0] & m;
        return s;
    endfunction

endpackage

// File: rtl/frac_pwm_dither.sv
module frac_pwm_dither
    import frac_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  dith_res_e         res,
    input  logic              down,
    input  logic [FRAC_W-1:0] inc,
    output logic              extra
);

    logic [FRAC_W-1:0] acc_q;
    dith_res_e         res_q;
    logic [FRAC_W-1:0] acc_eff;
    dith_step_t        st;

    // a resolution change restarts the pattern from zero
    assign acc_eff = (res != res_q) ? '0 : acc_q;
    assign st      = dith_step(acc_eff, inc, res, down);
    assign extra   = st.extra;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            res_q <= DITH_OFF;
        end else if (step) begin
            acc_q <= st.acc_nxt;
            res_q <= res;
        end
    end

    // R1: stored accumulator never leaves the range of its resolution
    p_acc_masked_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_q & ~res_mask(res_q)) == '0);

    // R5: a zero increment freezes the accumulator
    p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (step && inc == '0 && res == res_q) |=> (acc_q == $past(acc_q)));

endmodule

// File: rtl/frac_pwm_timebase.sv
module frac_pwm_timebase #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] nxt_len,
    input  logic [CW-1:0] nxt_wid,
    output logic          start,
    output logic          pwm_out,
    output logic          cyc_start
);

    logic          running;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len_q;
    logic [CW-1:0] wid_q;

    assign start = en && (!running || (cnt == len_q - CW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            len_q   <= '0;
            wid_q   <= '0;
        end else if (!en) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
            len_q   <= nxt_len;
            wid_q   <= nxt_wid;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign pwm_out   = running && (cnt < wid_q);
    assign cyc_start = running && (cnt == '0);

    // R10: the count stays inside the latched cycle length
    p_cnt_in_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt < len_q));

    // R9: latched lengths move only on a cycle boundary
    p_hold_midcycle_r9: assert property (@(posedge clk) disable iff (rst)
        (running && !start) |=> ($stable(len_q) && $stable(wid_q)));

    // R10: compare at or past the period keeps the output high
    p_full_high_r10: assert property (@(posedge clk) disable iff (rst)
        (running && wid_q >= len_q) |-> pwm_out);

    // R11: a running cycle is never zero clocks long
    p_len_nonzero_r11: assert property (@(posedge clk) disable iff (rst)
        running |-> (len_q != '0));

endmodule

// File: rtl/frac_pwm.sv
module frac_pwm
    import frac_pwm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        res_sel,
    input  logic              dir_down,
    input  logic [WORD_W-1:0] period_word,
    input  logic [WORD_W-1:0] cmp_word,
    output logic              pwm_out,
    output logic              cyc_start
);

    localparam int INT_W = WORD_W - FRAC_W;
    localparam int CW    = INT_W + 1;
    localparam int NACC  = 2;

    dith_res_e         res_e;
    logic [INT_W-1:0]  per_int;
    logic [INT_W-1:0]  cmp_int;
    logic [FRAC_W-1:0] inc_arr [NACC];
    logic [NACC-1:0]   extra_v;
    logic [CW-1:0]     len_raw;
    logic [CW-1:0]     nxt_len;
    logic [CW-1:0]     nxt_wid;
    logic              start;

    assign res_e      = dith_res_e'(res_sel);
    assign per_int    = period_word[WORD_W-1:FRAC_W];
    assign cmp_int    = cmp_word[WORD_W-1:FRAC_W];
    assign inc_arr[0] = period_word[FRAC_W-1:0];
    assign inc_arr[1] = cmp_word[FRAC_W-1:0];

    // index 0 dithers the period, index 1 dithers the pulse width
    for (genvar g = 0; g < NACC; g++) begin : g_dith
        frac_pwm_dither u_dither (
            .clk   (clk),
            .rst   (rst),
            .step  (start),
            .res   (res_e),
            .down  (dir_down),
            .inc   (inc_arr[g]),
            .extra (extra_v[g])
        );
    end

    assign len_raw = {1'b0, per_int} + CW'(extra_v[0]);
    assign nxt_len = (len_raw == '0) ? CW'(1) : len_raw;
    assign nxt_wid = {1'b0, cmp_int} + CW'(extra_v[1]);

    frac_pwm_timebase #(.CW(CW)) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .nxt_len   (nxt_len),
        .nxt_wid   (nxt_wid),
        .start     (start),
        .pwm_out   (pwm_out),
        .cyc_start (cyc_start)
    );

    // R11: nothing toggles while held in reset-like idle
    p_idle_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (!pwm_out && !cyc_start));

endmodule

// File: tb/frac_pwm_test.sv
module frac_pwm_test;

    localparam int WORD_W = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              en;
    logic [1:0]        res_sel;
    logic              dir_down;
    logic [WORD_W-1:0] period_word;
    logic [WORD_W-1:0] cmp_word;
    logic              pwm_out;
    logic              cyc_start;

    frac_pwm #(.WORD_W(WORD_W)) uut (
        .clk(clk), .rst(rst), .en(en), .res_sel(res_sel), .dir_down(dir_down),
        .period_word(period_word), .cmp_word(cmp_word),
        .pwm_out(pwm_out), .cyc_start(cyc_start)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    len;
        int    hi;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    bit   mon_on = 0;
    bit   seen_start = 0;
    int   cur_len = 0;
    int   cur_hi = 0;
    int   sum_len = 0;
    int   sum_hi = 0;
    int   m_acc_p = 0;
    int   m_acc_c = 0;
    int   m_res = 0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // expected cycle from the requirement rules (R1..R5, R8, R10, R11)
    task automatic push_next(int pint, int pinc, int cint, int cinc, int res, int dir, string tag);
        int mask;
        int sp;
        int sc;
        int ep;
        int ec;
        int len;
        int w;
        if (res != m_res) begin
            m_acc_p = 0;
            m_acc_c = 0;
            m_res   = res;
        end
        mask = (res == 1) ? 15 : (res == 2) ? 31 : (res == 3) ? 63 : 0;
        sp = m_acc_p + pinc;
        sc = m_acc_c + cinc;
        ep = 0;
        ec = 0;
        if (res != 0 && pinc != 0) ep = (dir != 0) ? ((sp > mask) ? 0 : 1) : ((sp > mask) ? 1 : 0);
        if (res != 0 && cinc != 0) ec = (dir != 0) ? ((sc > mask) ? 0 : 1) : ((sc > mask) ? 1 : 0);
        m_acc_p = sp & mask;
        m_acc_c = sc & mask;
        len = pint + ep;
        if (len == 0) len = 1;
        w = cint + ec;
        q.push_back('{len, (w >= len) ? len : w, tag});
    endtask

    task automatic wait_start;
        do @(negedge clk); while (!cyc_start);
    endtask

    task automatic drive(int pint, int pinc, int cint, int cinc, int res, int dir);
        period_word = WORD_W'((pint << 6) | pinc);
        cmp_word    = WORD_W'((cint << 6) | cinc);
        res_sel     = 2'(res);
        dir_down    = dir[0];
    endtask

    task automatic run(int pint, int pinc, int cint, int cinc, int res, int dir, int n, string tag);
        drive(pint, pinc, cint, cinc, res, dir);
        for (int i = 0; i < n; i++) begin
            push_next(pint, pinc, cint, cinc, res, dir, tag);
            wait_start();
        end
    endtask

    // monitor: measure each completed cycle and compare with the queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (cyc_start) begin
                if (seen_start) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R10", "unexpected cycle", cur_len, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(cur_len == e.len, e.tag, "period", cur_len, e.len);
                        check(cur_hi == e.hi, e.tag, "high time", cur_hi, e.hi);
                        sum_len += cur_len;
                        sum_hi  += cur_hi;
                    end
                end
                seen_start = 1;
                cur_len = 1;
                cur_hi  = pwm_out ? 1 : 0;
            end else if (seen_start) begin
                cur_len++;
                if (pwm_out) cur_hi++;
            end
        end
    end

    task automatic window(int pint, int pinc, int cint, int cinc, int res, int dir, int n,
                          int exp_len, int exp_hi, string tl, string th);
        int l0;
        int h0;
        run(pint, pinc, cint, cinc, res, dir, 1, tl);
        #1;
        l0 = sum_len;
        h0 = sum_hi;
        run(pint, pinc, cint, cinc, res, dir, n, tl);
        #1;
        check(sum_len - l0 == exp_len, tl, "window period sum", sum_len - l0, exp_len);
        check(sum_hi - h0 == exp_hi, th, "window high sum", sum_hi - h0, exp_hi);
    endtask

    initial begin
        rst = 1'b1;
        en  = 1'b0;
        drive(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check(!pwm_out && !cyc_start, "R11", "outputs in reset", {pwm_out, cyc_start}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!pwm_out && !cyc_start, "R11", "outputs idle", {pwm_out, cyc_start}, 0);

        // R11: first cycle starts on the first edge with en high
        mon_on = 1;
        drive(10, 0, 4, 0, 0, 0);
        en = 1'b1;
        push_next(10, 0, 4, 0, 0, 0, "R10");
        @(negedge clk);
        check(cyc_start == 1'b1, "R11", "first cycle strobe", cyc_start, 1);
        run(10, 0, 4, 0, 0, 0, 3, "R10");

        // R2/R3/R6/R7: 4-bit up, both fractions non-zero
        window(10, 5, 4, 3, 1, 0, 16, 16 * 10 + 5, 16 * 4 + 3, "R6", "R7");
        // R4/R5: 5-bit down, compare increment zero
        window(12, 7, 5, 0, 2, 1, 32, 32 * 12 + (32 - 7), 32 * 5, "R4", "R5");
        // R1/R7: 6-bit, period fixed, pulse dithered
        window(20, 0, 8, 37, 3, 0, 64, 64 * 20, 64 * 8 + 37, "R7", "R1");

        // R3 then R8: move accumulators, then change resolution
        run(9, 9, 3, 2, 1, 0, 5, "R3");
        run(9, 9, 3, 2, 2, 0, 6, "R8");
        run(7, 3, 2, 11, 1, 1, 8, "R4");

        // R9: alter words mid-cycle, restore before the boundary
        run(20, 0, 5, 0, 0, 0, 1, "R9");
        repeat (5) @(negedge clk);
        drive(3, 17, 1, 9, 3, 1);
        repeat (5) @(negedge clk);
        run(20, 0, 5, 0, 0, 0, 2, "R9");

        // R10 boundaries: compare above, equal, zero
        run(6, 0, 9, 0, 0, 0, 3, "R10");
        run(6, 0, 6, 0, 0, 0, 2, "R10");
        run(6, 0, 0, 0, 0, 0, 2, "R10");
        // R11: integer period zero runs as one clock
        run(0, 0, 0, 0, 0, 0, 4, "R11");
        run(5, 0, 2, 0, 0, 0, 2, "R10");

        // R11: en low stops the outputs
        mon_on = 0;
        en = 1'b0;
        repeat (3) @(negedge clk);
        check(!pwm_out && !cyc_start, "R11", "outputs with en low", {pwm_out, cyc_start}, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule